// File: doc/BRIEF.md
# Paired Instruction Fetch Splitter

This block sits between an instruction fetch port and a decoder. Every 32-bit fetch word it accepts is either a single long instruction or a pair of 16-bit short instructions. Bit 31 of the word tells the two apart. The block hands the instructions to the decoder one per handshake. Each presented slot carries its own address, and a pair member also carries a flag that says it issues alongside the slot before it.

The block owns the fetch address. That address moves forward by one word each time a word is taken. A redirect input discards whatever is buffered and restarts fetch at a word-aligned address.

For the slot currently presented, the block also works out the PC-relative branch target, whether the slot is a call, the link address a call would write, and the aligned target of a register-indirect jump. The decoder can therefore use these values without its own adders.

Top module: `fetch_pair_splitter`

## Requirements
- R1: When bit 31 of a taken fetch word is 1, the word is presented as one slot: `is_long_o`=1, `instr_o` equal to the whole word, `instr_pc_o` equal to the word's fetch address, and `is_parallel_o`=0.
- R2: When bit 31 is 0, two slots are presented in order. The first is bits 31:16 zero-extended to 32 bits, at the word's address. The second is bits 15:0 (with bit 15 handled as in R3) at the word's address plus 2. Both slots have `is_long_o`=0.
- R3: In the second slot of a pair, `is_parallel_o` equals bit 15 of the word, and bit 15 of `instr_o` is forced to 0. The first slot of a pair and a long slot always have `is_parallel_o`=0.
- R4: `fetch_pc_o` resets to the `RESET_PC` parameter with bits 1:0 cleared. It increases by 4 on every edge where `fetch_valid_i` and `fetch_ready_o` are both high. A word is accepted only when the buffer is empty, or when its last slot is being taken in that same cycle.
- R5: While `instr_valid_o`=1 and `instr_ready_i`=0, the slot and its address stay unchanged, and `fetch_ready_o` stays 0.
- R6: When `redirect_i` is high at an edge, any buffered slot is dropped: `instr_valid_o` is 0 after that edge. `fetch_pc_o` becomes `redirect_pc_i` with bits 1:0 cleared. `fetch_ready_o` is 0 in that cycle.
- R7: For a short slot whose bits 15:12 are 0111 and bits 11:10 are 11, `is_branch_o`=1. `branch_target_o` is (`instr_pc_o` with bits 1:0 cleared) plus the sign-extended bits 7:0 times 4.
- R8: For a long slot whose bits 31:28 are 1011, `is_branch_o`=1. The target is the aligned slot address plus the sign-extended bits 15:0 times 4.
- R9: For a long slot whose bits 31:28 are 1111 and bits 27:26 are 11, `is_branch_o`=1. The target is the aligned slot address plus bits 23:0, sign-extended from bit 23, times 4.
- R10: `is_call_o`=1 for the branches of R7 whose bits 11:8 are 1110, and for the branches of R9 whose bits 27:24 are 1110. `link_addr_o` always equals the aligned slot address plus 4, so a call in the first half of a pair returns to the next word.
- R11: `jump_target_o` equals `jump_src_i` with bits 1:0 cleared.
- R12: After reset, `instr_valid_o` is 0 and `fetch_ready_o` is 1. Slots that match none of R7 to R9 have `is_branch_o`=0 and `is_call_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_valid_i | input | 1 | Fetch word available |
| fetch_word_i | input | 32 | Fetch word |
| fetch_ready_o | output | 1 | Block takes the fetch word this cycle |
| fetch_pc_o | output | AW | Address of the word to fetch next |
| redirect_i | input | 1 | Flush and restart fetch |
| redirect_pc_i | input | AW | Restart address |
| instr_valid_o | output | 1 | A slot is presented |
| instr_ready_i | input | 1 | Decoder takes the slot |
| instr_o | output | 32 | Slot instruction, short forms zero-extended |
| is_long_o | output | 1 | Slot is a 32-bit instruction |
| is_parallel_o | output | 1 | Slot issues in parallel with the previous one |
| instr_pc_o | output | AW | Slot address |
| is_branch_o | output | 1 | Slot is a PC-relative branch |
| branch_target_o | output | AW | PC-relative target |
| is_call_o | output | 1 | Branch writes a link address |
| link_addr_o | output | AW | Return address for a call |
| jump_src_i | input | AW | Register value for an indirect jump |
| jump_target_o | output | AW | Aligned indirect jump target |

## Verification
The first slot of a word is due one edge after the fetch handshake. The second half of a pair follows one edge after the first slot is taken. `fetch_pc_o` changes on the handshake edge itself. A redirect clears `instr_valid_o` on the edge where it is seen. The branch, call, link and jump outputs follow the presented slot in the same cycle. The bench therefore drives at falling edges and reads each result at the falling edge right after the rising edge that should produce it. It sweeps displacement sign and width for every branch form, with the parallel bit both set and clear.

// File: rtl/fsplit_pkg.sv
`timescale 1ns/1ps
package fsplit_pkg;
  localparam int WORD_W = 32;
  localparam int HALF_W = 16;

  typedef enum logic [1:0] {
    DISP_NONE = 2'd0,
    DISP_8    = 2'd1,
    DISP_16   = 2'd2,
    DISP_24   = 2'd3
  } disp_kind_e;
endpackage

// File: rtl/fsplit_pc_gen.sv
`timescale 1ns/1ps
module fsplit_pc_gen #(
  parameter int            AW       = 32,
  parameter logic [AW-1:0] RESET_PC = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          advance_i,
  input  logic          redirect_i,
  input  logic [AW-1:0] redirect_pc_i,
  output logic [AW-1:0] pc_o
);
  localparam logic [AW-1:0] STEP       = AW'(4);
  localparam logic [AW-1:0] ALIGN_MASK = ~AW'(3);

  logic [AW-1:0] pc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         pc_q <= RESET_PC & ALIGN_MASK;
    else if (redirect_i) pc_q <= redirect_pc_i & ALIGN_MASK;
    else if (advance_i)  pc_q <= pc_q + STEP;
  end

  assign pc_o = pc_q;

  p_step_word_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    advance_i && !redirect_i |=> pc_o == $past(pc_o) + STEP);

  p_restart_aligned_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_i |=> pc_o == ($past(redirect_pc_i) & ALIGN_MASK));
endmodule

// File: rtl/fsplit_slot_buf.sv
`timescale 1ns/1ps
module fsplit_slot_buf
  import fsplit_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic [AW-1:0]     word_pc_i,
  input  logic              flush_i,
  input  logic              out_ready_i,
  output logic              can_load_o,
  output logic              valid_o,
  output logic [WORD_W-1:0] instr_o,
  output logic              is_long_o,
  output logic              is_parallel_o,
  output logic [AW-1:0]     pc_o
);
  localparam int            PAR_BIT   = HALF_W - 1;
  localparam logic [AW-1:0] HALF_STEP = AW'(HALF_W / 8);

  logic              full_q, second_q;
  logic [WORD_W-1:0] word_q;
  logic [AW-1:0]     pc_q;
  logic              long_w, last_w, take_w;

  assign long_w     = word_q[WORD_W-1];
  assign last_w     = long_w | second_q;
  assign take_w     = full_q & out_ready_i;
  assign can_load_o = !full_q | (take_w & last_w);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q   <= 1'b0;
      second_q <= 1'b0;
      word_q   <= '0;
      pc_q     <= '0;
    end else if (flush_i) begin
      full_q   <= 1'b0;
      second_q <= 1'b0;
    end else if (load_i) begin
      full_q   <= 1'b1;
      second_q <= 1'b0;
      word_q   <= word_i;
      pc_q     <= word_pc_i;
    end else if (take_w) begin
      if (last_w) full_q   <= 1'b0;
      else        second_q <= 1'b1;
    end
  end

  always_comb begin
    valid_o       = full_q;
    instr_o       = '0;
    is_long_o     = 1'b0;
    is_parallel_o = 1'b0;
    pc_o          = '0;
    if (full_q) begin
      if (long_w) begin
        instr_o   = word_q;
        is_long_o = 1'b1;
        pc_o      = pc_q;
      end else if (!second_q) begin
        instr_o = {{(WORD_W-HALF_W){1'b0}}, word_q[WORD_W-1:HALF_W]};
        pc_o    = pc_q;
      end else begin
        // parallel marker is stripped before the halfword leaves
        instr_o       = {{(WORD_W-PAR_BIT){1'b0}}, word_q[PAR_BIT-1:0]};
        is_parallel_o = word_q[PAR_BIT];
        pc_o          = pc_q + HALF_STEP;
      end
    end
  end

  p_hold_slot_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !out_ready_i && !flush_i |=>
      valid_o && $stable(instr_o) && $stable(pc_o) && $stable(is_parallel_o));

  p_second_half_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && out_ready_i && !last_w && !flush_i |=>
      valid_o && !is_long_o && pc_o == $past(pc_o) + HALF_STEP);

  p_flush_empty_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !valid_o);

  p_short_cleared_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !is_long_o |-> instr_o[WORD_W-1:PAR_BIT] == '0);
endmodule

// File: rtl/fsplit_target.sv
`timescale 1ns/1ps
module fsplit_target
  import fsplit_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [WORD_W-1:0] instr_i,
  input  logic              valid_i,
  input  logic              is_long_i,
  input  logic [AW-1:0]     pc_i,
  input  logic [AW-1:0]     jump_src_i,
  output logic              is_branch_o,
  output logic [AW-1:0]     target_o,
  output logic              is_call_o,
  output logic [AW-1:0]     link_o,
  output logic [AW-1:0]     jump_target_o
);
  localparam logic [AW-1:0] ALIGN_MASK = ~AW'(3);
  localparam logic [AW-1:0] WORD_STEP  = AW'(4);

  disp_kind_e    kind;
  logic          call_w;
  logic [AW-1:0] base, disp, offset;

  always_comb begin
    kind   = DISP_NONE;
    call_w = 1'b0;
    if (valid_i) begin
      if (is_long_i) begin
        if (instr_i[31:28] == 4'hb) begin
          kind = DISP_16;
        end else if (instr_i[31:28] == 4'hf && instr_i[27:26] == 2'b11) begin
          kind   = DISP_24;
          call_w = instr_i[25:24] == 2'b10;
        end
      end else if (instr_i[15:12] == 4'h7 && instr_i[11:10] == 2'b11) begin
        kind   = DISP_8;
        call_w = instr_i[9:8] == 2'b10;
      end
    end
  end

  always_comb begin
    unique case (kind)
      DISP_8:  disp = {{(AW-8){instr_i[7]}}, instr_i[7:0]};
      DISP_16: disp = {{(AW-16){instr_i[15]}}, instr_i[15:0]};
      DISP_24: disp = {{(AW-24){instr_i[23]}}, instr_i[23:0]};
      default: disp = '0;
    endcase
  end

  assign base          = pc_i & ALIGN_MASK;
  assign offset        = {disp[AW-3:0], 2'b00};
  assign is_branch_o   = kind != DISP_NONE;
  assign target_o      = base + offset;
  assign is_call_o     = call_w;
  assign link_o        = base + WORD_STEP;
  assign jump_target_o = jump_src_i & ALIGN_MASK;

  always_comb begin
    p_target_word_r7: assert (target_o[1:0] == 2'b00);
    p_call_is_branch_r10: assert (!is_call_o || is_branch_o);
  end
endmodule

// File: rtl/fetch_pair_splitter.sv
`timescale 1ns/1ps
module fetch_pair_splitter
  import fsplit_pkg::*;
#(
  parameter int            AW       = 32,
  parameter logic [AW-1:0] RESET_PC = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fetch_valid_i,
  input  logic [31:0]   fetch_word_i,
  output logic          fetch_ready_o,
  output logic [AW-1:0] fetch_pc_o,
  input  logic          redirect_i,
  input  logic [AW-1:0] redirect_pc_i,
  output logic          instr_valid_o,
  input  logic          instr_ready_i,
  output logic [31:0]   instr_o,
  output logic          is_long_o,
  output logic          is_parallel_o,
  output logic [AW-1:0] instr_pc_o,
  output logic          is_branch_o,
  output logic [AW-1:0] branch_target_o,
  output logic          is_call_o,
  output logic [AW-1:0] link_addr_o,
  input  logic [AW-1:0] jump_src_i,
  output logic [AW-1:0] jump_target_o
);
  logic can_load, load;

  assign fetch_ready_o = can_load & !redirect_i;
  assign load          = fetch_valid_i & fetch_ready_o;

  fsplit_pc_gen #(.AW(AW), .RESET_PC(RESET_PC)) u_pc (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .advance_i     (load),
    .redirect_i    (redirect_i),
    .redirect_pc_i (redirect_pc_i),
    .pc_o          (fetch_pc_o)
  );

  fsplit_slot_buf #(.AW(AW)) u_buf (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .load_i        (load),
    .word_i        (fetch_word_i),
    .word_pc_i     (fetch_pc_o),
    .flush_i       (redirect_i),
    .out_ready_i   (instr_ready_i),
    .can_load_o    (can_load),
    .valid_o       (instr_valid_o),
    .instr_o       (instr_o),
    .is_long_o     (is_long_o),
    .is_parallel_o (is_parallel_o),
    .pc_o          (instr_pc_o)
  );

  fsplit_target #(.AW(AW)) u_tgt (
    .instr_i       (instr_o),
    .valid_i       (instr_valid_o),
    .is_long_i     (is_long_o),
    .pc_i          (instr_pc_o),
    .jump_src_i    (jump_src_i),
    .is_branch_o   (is_branch_o),
    .target_o      (branch_target_o),
    .is_call_o     (is_call_o),
    .link_o        (link_addr_o),
    .jump_target_o (jump_target_o)
  );

  p_no_fetch_on_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    instr_valid_o && !instr_ready_i |-> !fetch_ready_o);
endmodule

// File: tb/fetch_pair_splitter_tb_top.sv
`timescale 1ns/1ps
module fetch_pair_splitter_tb_top;
  localparam int          AW = 32;
  localparam logic [31:0] RST_PC = 32'h0000_0102;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          fetch_valid = 1'b0;
  logic [31:0]   fetch_word = '0;
  logic          fetch_ready;
  logic [AW-1:0] fetch_pc;
  logic          redirect = 1'b0;
  logic [AW-1:0] redirect_pc = '0;
  logic          instr_valid;
  logic          instr_ready = 1'b1;
  logic [31:0]   instr;
  logic          is_long, is_par, is_branch, is_call;
  logic [AW-1:0] instr_pc, br_tgt, link_addr;
  logic [AW-1:0] jump_src = '0;
  logic [AW-1:0] jump_tgt;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [31:0] exp_fpc;

  always #5 clk = ~clk;

  fetch_pair_splitter #(.AW(AW), .RESET_PC(RST_PC)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .fetch_valid_i(fetch_valid), .fetch_word_i(fetch_word),
    .fetch_ready_o(fetch_ready), .fetch_pc_o(fetch_pc),
    .redirect_i(redirect), .redirect_pc_i(redirect_pc),
    .instr_valid_o(instr_valid), .instr_ready_i(instr_ready),
    .instr_o(instr), .is_long_o(is_long), .is_parallel_o(is_par),
    .instr_pc_o(instr_pc), .is_branch_o(is_branch),
    .branch_target_o(br_tgt), .is_call_o(is_call),
    .link_addr_o(link_addr), .jump_src_i(jump_src),
    .jump_target_o(jump_tgt)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic check_slot(input logic [31:0] ins, input bit lng,
                            input bit par, input logic [31:0] pc);
    logic [31:0] base = pc & ~32'd3;
    int d = 0;
    bit br = 0, call = 0;
    if (lng) begin
      if (ins[31:28] == 4'hb) begin
        br = 1; d = int'($signed(ins[15:0]));
      end else if (ins[31:28] == 4'hf && ins[27:26] == 2'b11) begin
        br = 1; d = int'(ins[23:0]);
        if (d >= (1 << 23)) d = d - (1 << 24);
        call = ins[27:24] == 4'he;
      end
    end else if (ins[15:12] == 4'h7 && ins[11:10] == 2'b11) begin
      br = 1; d = int'($signed(ins[7:0]));
      call = ins[11:8] == 4'he;
    end
    chk(lng ? "R1" : "R2", "valid", 32'(instr_valid), 32'd1);
    chk(lng ? "R1" : "R2", "instr", instr, ins);
    chk(lng ? "R1" : "R2", "pc", instr_pc, pc);
    chk("R1", "is_long", 32'(is_long), 32'(lng));
    chk("R3", "parallel", 32'(is_par), 32'(par));
    chk(lng ? (ins[31:28] == 4'hb ? "R8" : "R9") : "R7", "is_branch",
        32'(is_branch), 32'(br));
    if (br) chk(lng ? (ins[31:28] == 4'hb ? "R8" : "R9") : "R7", "target",
                br_tgt, base + 32'(d * 4));
    chk("R10", "is_call", 32'(is_call), 32'(call));
    chk("R10", "link", link_addr, base + 32'd4);
  endtask

  task automatic run_word(input logic [31:0] w);
    logic [31:0] pc0;
    @(negedge clk);
    fetch_valid = 1'b1; fetch_word = w;
    chk("R4", "fetch_ready", 32'(fetch_ready), 32'd1);
    pc0 = fetch_pc;
    chk("R4", "fetch_pc", pc0, exp_fpc);
    @(negedge clk);
    fetch_valid = 1'b0;
    if (w[31]) begin
      check_slot(w, 1'b1, 1'b0, pc0);
    end else begin
      check_slot({16'h0, w[31:16]}, 1'b0, 1'b0, pc0);
      @(negedge clk);
      check_slot({17'h0, w[14:0]}, 1'b0, w[15], pc0 + 32'd2);
    end
    @(negedge clk);
    chk("R2", "drained", 32'(instr_valid), 32'd0);
    exp_fpc = exp_fpc + 32'd4;
    chk("R4", "fetch_pc step", fetch_pc, exp_fpc);
  endtask

  initial begin
    logic [31:0] snap_i, snap_p;
    exp_fpc = RST_PC & ~32'd3;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12", "reset valid", 32'(instr_valid), 32'd0);
    chk("R12", "reset ready", 32'(fetch_ready), 32'd1);
    chk("R4", "reset pc", fetch_pc, exp_fpc);

    for (int k = 0; k < 16; k++) begin
      logic [23:0] d24 = 24'(k * 32'h1d3a7) ^ (k[0] ? 24'h80_0000 : 24'h0);
      run_word({4'hf, 2'b11, 2'(k), d24});                         // R9 R10
    end
    for (int k = 0; k < 16; k++) begin
      logic [15:0] d16 = 16'(k * 32'h1357) ^ (k[1] ? 16'h8000 : 16'h0);
      run_word({4'hb, 4'(k), 4'(k) ^ 4'h5, 4'h0, d16});            // R8
    end
    for (int k = 0; k < 16; k++) begin
      logic [7:0] da = 8'(k * 37) ^ (k[2] ? 8'h80 : 8'h00);
      logic [7:0] db = 8'(k * 91 + 3);
      run_word({4'h7, 2'b11, 2'(k), da, k[0], 3'b111, 2'b11, 2'(k >> 2), db}); // R3 R7
    end
    for (int k = 0; k < 8; k++) begin
      run_word({k[0], 3'b000, 28'(32'h0123_4567 + k * 32'h0101_0101)}); // R12
      run_word({1'b0, 3'(k), 12'hA5C, ~k[1], 15'(k * 32'h0f0f)});   // R3
    end

    // R5: decoder stalls on the first half of a pair
    @(negedge clk);
    fetch_valid = 1'b1; fetch_word = 32'h7C10_FD80; instr_ready = 1'b0;
    @(negedge clk);
    fetch_valid = 1'b0;
    snap_i = instr; snap_p = instr_pc;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk("R5", "hold valid", 32'(instr_valid), 32'd1);
      chk("R5", "hold instr", instr, snap_i);
      chk("R5", "hold pc", instr_pc, snap_p);
      chk("R5", "no fetch", 32'(fetch_ready), 32'd0);
    end
    instr_ready = 1'b1;
    @(negedge clk);
    check_slot(32'h0000_7D80, 1'b0, 1'b1, snap_p + 32'd2);
    @(negedge clk);
    exp_fpc = exp_fpc + 32'd4;

    // R6: redirect while the second half is pending
    @(negedge clk);
    fetch_valid = 1'b1; fetch_word = 32'h1234_0567;
    @(negedge clk);
    fetch_valid = 1'b0;
    redirect = 1'b1; redirect_pc = 32'h0000_2347;
    chk("R6", "ready during redirect", 32'(fetch_ready), 32'd0);
    @(negedge clk);
    redirect = 1'b0;
    chk("R6", "flushed", 32'(instr_valid), 32'd0);
    chk("R6", "restart pc", fetch_pc, 32'h0000_2344);
    exp_fpc = 32'h0000_2344;
    run_word(32'hF7FF_FFFF);

    // R11: indirect jump alignment
    for (int k = 0; k < 16; k++) begin
      jump_src = 32'(k * 32'h1357_9BDF + k);
      #1;
      chk("R11", "jump target", jump_tgt, jump_src & ~32'd3);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule